// File: doc/BRIEF.md
# Virtual-Channel Router Input Pipeline

This block is the control for one input port of a wormhole router that uses virtual channels. Flits arrive tagged as head, body, tail or single (head and tail at once), each carrying the number of the input virtual channel it belongs to. Every input channel has its own flit queue. A head flit spends one cycle in route computation, where dimension-ordered XY routing is applied to the destination carried in its payload. It then spends at least one cycle in downstream channel allocation and at least one in switch allocation. After a win it leaves through a registered switch-traversal stage. Body and tail flits skip the first two stages. They reuse the output port and downstream channel that their head obtained, so they go straight to switch allocation.

The block keeps the busy state of every downstream channel on every output port. A channel is handed out at allocation time and reclaimed as soon as the tail flit of its packet wins the switch. No signal returns from downstream for this. Each sent flit carries the downstream channel number, so both sides agree on which channel is in use. A plain per-output `out_block` input stands for a conflict that is lost elsewhere in the switch. A flit whose output is blocked stays queued and retries every cycle. Because a queue drains in order, the flits behind it wait as well.

Flit input is valid/ready. A flit is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends combinationally on `in_vc`, so the source holds all flit fields stable while `in_valid` is high. The traversal output is valid-only and cannot be stalled. Back-pressure toward the switch is expressed only through `out_block`.

Top module: `vcr_input_pipe`

## Requirements
- R1: After reset, `out_valid` is 0, every stage-trace field is 0 (idle), and `in_ready` is 1 for any channel number below the channel count.
- R2: A head flit's destination is x = `in_data[CW-1:0]` and y = `in_data[2*CW-1:CW]`. It is routed east (port 1) if dest x > `my_x`, west (2) if dest x < `my_x`, otherwise north (3) if dest y > `my_y`, south (4) if dest y < `my_y`, otherwise local (0).
- R3: Stage trace field v is `stage_trace[2v+1:2v]`, with codes 1 = route computation, 2 = channel allocation and 3 = switch allocation. With nothing in its way, a head flit taken at edge E shows code 1, 2 and 3 in the cycles after E, E+1 and E+2. It appears on the output in the cycle after edge E+3.
- R4: Kind encoding: 01 head, 00 body, 10 tail, 11 single. Body and tail flits of a packet need no route computation or allocation. A packet fed in back-to-back leaves in consecutive cycles, in order, with the same `out_port` and `out_vc` as its head.
- R5: Channel allocation gives the lowest-numbered free downstream channel on the routed port, with lower input channels served first. When none is free, the head flit stays in allocation (trace code 2) and nothing from that channel is sent.
- R6: The downstream channel of a packet is free again in the cycle its tail flit appears on the output. A head waiting on that port is granted it then and is sent two cycles after the tail.
- R7: A flit whose routed port has `out_block` set does not win the switch. It stays at trace code 3 and is not sent, and the flits behind it in its channel wait. It is sent in the cycle after the first cycle its port is unblocked.
- R8: Among input channels requesting the switch in the same cycle, the grant rotates round-robin, one flit per cycle. The priority moves past the winner after each grant.
- R9: Each input channel holds `DEPTH` flits. With a full channel, `in_ready` is 0 when `in_vc` names it and the offered flit is dropped, while other channels stay ready. A channel number at or above the channel count is never ready.
- R10: `out_data` and `out_kind` equal the data and kind of the flit as it was taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | CW | X coordinate of this router |
| my_y | input | CW | Y coordinate of this router |
| in_valid | input | 1 | Input flit offered |
| in_ready | output | 1 | Queue of channel `in_vc` can take a flit |
| in_vc | input | VW | Input channel number of the offered flit |
| in_kind | input | 2 | Flit kind (R4 encoding) |
| in_data | input | DW | Flit payload; head carries destination (R2) |
| out_block | input | 5 | Per output port: switch conflict lost this cycle |
| out_valid | output | 1 | Switch-traversal flit present |
| out_port | output | 3 | Output port of the sent flit (R2 encoding) |
| out_vc | output | OW | Downstream channel of the sent flit |
| out_kind | output | 2 | Kind of the sent flit |
| out_data | output | DW | Payload of the sent flit |
| stage_trace | output | 2*NUM_VC | Per input channel stage code of its front flit (R3) |

## Verification
The assertions take the flit stream to be well formed per channel. A head opens a packet, body flits follow, and a tail or single closes it. No head arrives while that channel's packet is still open, and no body or tail arrives outside a packet. They also take `out_block` to be sampled like any synchronous input. The stimulus keeps to this by sending whole packets per channel, opening each packet with a head and closing it with a tail. It changes `out_block` and the flit inputs only on falling clock edges. The only out-of-range value it offers is a channel number at or above the channel count, and it offers that only to observe `in_ready`.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_EAST  = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_SOUTH = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VA   = 2'd1,
    ST_SA   = 2'd2
  } vc_state_e;

  localparam logic [1:0] TR_IDLE = 2'd0;
  localparam logic [1:0] TR_RC   = 2'd1;
  localparam logic [1:0] TR_VA   = 2'd2;
  localparam logic [1:0] TR_SA   = 2'd3;

  // dimension-ordered: resolve x first, then y
  function automatic logic [2:0] xy_route(input logic [7:0] cx, input logic [7:0] cy,
                                          input logic [7:0] dx, input logic [7:0] dy);
    logic [2:0] p;
    if (dx > cx)      p = P_EAST;
    else if (dx < cx) p = P_WEST;
    else if (dy > cy) p = P_NORTH;
    else if (dy < cy) p = P_SOUTH;
    else              p = P_LOCAL;
    return p;
  endfunction
endpackage

// File: rtl/vcr_flit_fifo.sv
module vcr_flit_fifo #(
  parameter int FW    = 18,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [FW-1:0] wdata,
  input  logic          pop,
  output logic [FW-1:0] rdata,
  output logic          not_empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [FW-1:0]   mem [DEPTH];
  logic [AW-1:0]   rd_q, wr_q;
  logic [CNTW-1:0] cnt_q;

  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CNTW'(DEPTH));
  assign rdata     = mem[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> not_empty);
endmodule

// File: rtl/vcr_ovc_table.sv
module vcr_ovc_table
  import vcr_pkg::*;
#(
  parameter int NUM_VC  = 3,
  parameter int NUM_OVC = 2,
  localparam int OW = (NUM_OVC > 1) ? $clog2(NUM_OVC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] req,
  input  logic [2:0]        req_port [NUM_VC],
  output logic [NUM_VC-1:0] gnt,
  output logic [OW-1:0]     gnt_ovc  [NUM_VC],
  input  logic              rel,
  input  logic [2:0]        rel_port,
  input  logic [OW-1:0]     rel_ovc
);
  logic [NUM_OVC-1:0] busy_q [NPORT];
  logic [NUM_OVC-1:0] busy_d [NPORT];

  always_comb begin
    for (int p = 0; p < NPORT; p++) busy_d[p] = busy_q[p];
    for (int v = 0; v < NUM_VC; v++) begin
      gnt[v]     = 1'b0;
      gnt_ovc[v] = '0;
      if (req[v] && (int'(req_port[v]) < NPORT)) begin
        for (int o = 0; o < NUM_OVC; o++) begin
          if (!gnt[v] && !busy_d[req_port[v]][o]) begin
            gnt[v]                  = 1'b1;
            gnt_ovc[v]              = OW'(o);
            busy_d[req_port[v]][o]  = 1'b1;
          end
        end
      end
    end
    if (rel && (int'(rel_port) < NPORT)) busy_d[rel_port][rel_ovc] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) busy_q[p] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) busy_q[p] <= busy_d[p];
    end
  end

  // R6
  release_of_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> busy_q[rel_port][rel_ovc]);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    // R5
    grant_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[v] |=> busy_q[$past(req_port[v])][$past(gnt_ovc[v])]);
    // R5
    grant_was_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[v] |-> !busy_q[req_port[v]][gnt_ovc[v]]);
  end
endmodule

// File: rtl/vcr_sw_arb.sv
module vcr_sw_arb #(
  parameter int N      = 3,
  parameter bit ARB_RR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  if (ARB_RR) begin : g_rr
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] win;
    always_comb begin
      gnt = '0;
      win = '0;
      for (int i = 0; i < N; i++) begin
        int idx;
        idx = (int'(ptr_q) + i) % N;
        if (gnt == '0 && req[idx]) begin
          gnt[idx] = 1'b1;
          win      = IW'(idx);
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else if (gnt != '0) ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
    end
  end else begin : g_fixed
    always_comb begin
      gnt = '0;
      for (int i = 0; i < N; i++) begin
        if (gnt == '0 && req[i]) gnt[i] = 1'b1;
      end
    end
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R8
  grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  // R8
  grant_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/vcr_input_pipe.sv
module vcr_input_pipe
  import vcr_pkg::*;
#(
  parameter int NUM_VC  = 3,
  parameter int DEPTH   = 4,
  parameter int DW      = 16,
  parameter int CW      = 2,
  parameter int NUM_OVC = 2,
  parameter bit ARB_RR  = 1'b1,
  localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int OW = (NUM_OVC > 1) ? $clog2(NUM_OVC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       my_x,
  input  logic [CW-1:0]       my_y,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [VW-1:0]       in_vc,
  input  logic [1:0]          in_kind,
  input  logic [DW-1:0]       in_data,
  input  logic [NPORT-1:0]    out_block,
  output logic                out_valid,
  output logic [2:0]          out_port,
  output logic [OW-1:0]       out_vc,
  output logic [1:0]          out_kind,
  output logic [DW-1:0]       out_data,
  output logic [2*NUM_VC-1:0] stage_trace
);
  localparam int FW = DW + 2;

  logic [NUM_VC-1:0] push, nempty, full, va_req, va_gnt, sa_req, sa_gnt;
  logic [FW-1:0]     hd      [NUM_VC];
  logic [2:0]        route_q [NUM_VC];
  logic [OW-1:0]     ovc_q   [NUM_VC];
  logic [OW-1:0]     va_ovc  [NUM_VC];
  vc_state_e         st_q    [NUM_VC];

  always_comb begin
    in_ready = 1'b0;
    for (int v = 0; v < NUM_VC; v++)
      if (in_vc == VW'(v)) in_ready = !full[v];
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic is_head, is_tail;
    assign is_head = hd[v][DW];
    assign is_tail = hd[v][DW+1];
    assign push[v] = in_valid && (in_vc == VW'(v)) && !full[v];

    vcr_flit_fifo #(.FW(FW), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push[v]), .wdata({in_kind, in_data}),
      .pop(sa_gnt[v]), .rdata(hd[v]),
      .not_empty(nempty[v]), .full(full[v])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[v]    <= ST_IDLE;
        route_q[v] <= '0;
        ovc_q[v]   <= '0;
      end else begin
        case (st_q[v])
          ST_IDLE: if (nempty[v] && is_head) begin
            route_q[v] <= xy_route(8'(my_x), 8'(my_y), 8'(hd[v][CW-1:0]), 8'(hd[v][2*CW-1:CW]));
            st_q[v]    <= ST_VA;
          end
          ST_VA: if (va_gnt[v]) begin
            ovc_q[v] <= va_ovc[v];
            st_q[v]  <= ST_SA;
          end
          ST_SA: if (sa_gnt[v] && is_tail) st_q[v] <= ST_IDLE;
          default: st_q[v] <= ST_IDLE;
        endcase
      end
    end

    assign va_req[v] = (st_q[v] == ST_VA);
    assign sa_req[v] = (st_q[v] == ST_SA) && nempty[v] && !out_block[route_q[v]];

    always_comb begin
      case (st_q[v])
        ST_IDLE: stage_trace[2*v +: 2] = (nempty[v] && is_head) ? TR_RC : TR_IDLE;
        ST_VA:   stage_trace[2*v +: 2] = TR_VA;
        ST_SA:   stage_trace[2*v +: 2] = TR_SA;
        default: stage_trace[2*v +: 2] = TR_IDLE;
      endcase
    end

    // R3
    rc_then_va_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[v] == ST_IDLE && nempty[v] && is_head) |=> (st_q[v] == ST_VA));
    // R7
    blocked_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[v] == ST_SA && nempty[v] && out_block[route_q[v]] && !push[v])
        |=> (st_q[v] == ST_SA && nempty[v] && $stable(hd[v])));
    // R4
    sa_route_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[v] == ST_SA) |=> (st_q[v] == ST_IDLE || ($stable(route_q[v]) && $stable(ovc_q[v]))));
  end

  vcr_ovc_table #(.NUM_VC(NUM_VC), .NUM_OVC(NUM_OVC)) i_ovc (
    .clk(clk), .rst_n(rst_n),
    .req(va_req), .req_port(route_q),
    .gnt(va_gnt), .gnt_ovc(va_ovc),
    .rel(rel), .rel_port(sel_port), .rel_ovc(sel_ovc)
  );

  vcr_sw_arb #(.N(NUM_VC), .ARB_RR(ARB_RR)) i_arb (
    .clk(clk), .rst_n(rst_n), .req(sa_req), .gnt(sa_gnt)
  );

  logic          rel;
  logic [2:0]    sel_port;
  logic [OW-1:0] sel_ovc;
  logic [FW-1:0] sel_flit;

  always_comb begin
    rel      = 1'b0;
    sel_port = '0;
    sel_ovc  = '0;
    sel_flit = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (sa_gnt[v]) begin
        sel_port = route_q[v];
        sel_ovc  = ovc_q[v];
        sel_flit = hd[v];
        rel      = hd[v][DW+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_vc    <= '0;
      out_kind  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= (sa_gnt != '0);
      if (sa_gnt != '0) begin
        out_port <= sel_port;
        out_vc   <= sel_ovc;
        out_kind <= sel_flit[DW+1:DW];
        out_data <= sel_flit[DW-1:0];
      end
    end
  end

  // R7
  sent_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$past(out_block[out_port]));
  // R9
  bad_vc_never_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(in_vc) >= NUM_VC) |-> !in_ready);
endmodule

// File: tb/test_vcr_input_pipe.sv
module test_vcr_input_pipe;
  localparam int NUM_VC = 3;
  localparam int DW = 16;
  localparam int CW = 2;
  localparam logic [1:0] K_BODY = 2'b00, K_HEAD = 2'b01, K_TAIL = 2'b10, K_ONE = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] my_x = 2'd1, my_y = 2'd2;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_vc = '0, in_kind = '0;
  logic [DW-1:0] in_data = '0;
  logic [4:0] out_block = '0;
  logic out_valid;
  logic [2:0] out_port;
  logic [0:0] out_vc;
  logic [1:0] out_kind;
  logic [DW-1:0] out_data;
  logic [2*NUM_VC-1:0] stage_trace;

  vcr_input_pipe i_vcr_input_pipe (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_vc(in_vc), .in_kind(in_kind),
    .in_data(in_data), .out_block(out_block), .out_valid(out_valid),
    .out_port(out_port), .out_vc(out_vc), .out_kind(out_kind),
    .out_data(out_data), .stage_trace(stage_trace)
  );

  always #10ns clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0, lg = 0;
  logic [2:0]    l_port [256];
  logic [0:0]    l_ovc  [256];
  logic [1:0]    l_kind [256];
  logic [DW-1:0] l_data [256];
  int            l_cyc  [256];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (out_valid && lg < 256) begin
    l_port[lg] = out_port; l_ovc[lg] = out_vc; l_kind[lg] = out_kind;
    l_data[lg] = out_data; l_cyc[lg] = cyc; lg = lg + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int vc, input logic [1:0] k, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_vc = 2'(vc); in_kind = k; in_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int exp_port(input int dx, input int dy);
    if (dx > 1) return 1;
    if (dx < 1) return 2;
    if (dy > 2) return 3;
    if (dy < 2) return 4;
    return 0;
  endfunction

  initial begin
    #4ms;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(stage_trace == '0, "R1", int'(stage_trace), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

    // R2 / R3: sweep every destination with single-flit packets
    for (int dx = 0; dx < 4; dx++) begin
      for (int dy = 0; dy < 4; dy++) begin
        logic [DW-1:0] d;
        d = {8'(dx * 4 + dy + 16), 4'h0, 2'(dy), 2'(dx)};
        send(0, K_ONE, d);
        idle();
        chk(stage_trace[1:0] == 2'd1, "R3", int'(stage_trace[1:0]), 1);
        tick(1);
        chk(stage_trace[1:0] == 2'd2, "R3", int'(stage_trace[1:0]), 2);
        tick(1);
        chk(stage_trace[1:0] == 2'd3, "R3", int'(stage_trace[1:0]), 3);
        chk(out_valid == 1'b0, "R3", int'(out_valid), 0);
        tick(1);
        chk(out_valid == 1'b1, "R3", int'(out_valid), 1);
        chk(int'(out_port) == exp_port(dx, dy), "R2", int'(out_port), exp_port(dx, dy));
        chk(out_vc == 1'b0, "R6", int'(out_vc), 0);
        chk(out_data == d && out_kind == K_ONE, "R10", int'(out_data), int'(d));
        tick(1);
      end
    end

    // R4: four-flit packet on channel 1 toward east
    base = lg;
    send(1, K_HEAD, 16'hA00B);
    send(1, K_BODY, 16'hB001);
    send(1, K_BODY, 16'hB002);
    send(1, K_TAIL, 16'hB003);
    idle(); tick(8);
    chk(lg - base == 4, "R4", lg - base, 4);
    for (int i = 0; i < 4; i++) begin
      logic [DW-1:0] ed;
      ed = (i == 0) ? 16'hA00B : 16'(16'hB000 + i);
      chk(l_port[base+i] == 3'd1, "R4", int'(l_port[base+i]), 1);
      chk(l_ovc[base+i] == l_ovc[base], "R4", int'(l_ovc[base+i]), int'(l_ovc[base]));
      chk(l_data[base+i] == ed, "R10", int'(l_data[base+i]), int'(ed));
      if (i > 0) chk(l_cyc[base+i] - l_cyc[base+i-1] == 1, "R4", l_cyc[base+i] - l_cyc[base+i-1], 1);
    end

    // R5 / R6: three heads on one port with two downstream channels
    base = lg;
    send(0, K_HEAD, 16'h100B);
    send(1, K_HEAD, 16'h200B);
    send(2, K_HEAD, 16'h300B);
    idle(); tick(8);
    chk(lg - base == 2, "R5", lg - base, 2);
    chk(l_ovc[base] == 1'b0, "R5", int'(l_ovc[base]), 0);
    chk(l_ovc[base+1] == 1'b1, "R5", int'(l_ovc[base+1]), 1);
    chk(stage_trace[5:4] == 2'd2, "R5", int'(stage_trace[5:4]), 2);
    send(0, K_TAIL, 16'h7000);
    idle(); tick(6);
    chk(lg - base == 4, "R6", lg - base, 4);
    chk(l_data[base+3] == 16'h300B, "R6", int'(l_data[base+3]), 16'h300B);
    chk(l_ovc[base+3] == 1'b0, "R6", int'(l_ovc[base+3]), 0);
    chk(l_cyc[base+3] - l_cyc[base+2] == 2, "R6", l_cyc[base+3] - l_cyc[base+2], 2);
    send(1, K_TAIL, 16'h7001);
    send(2, K_TAIL, 16'h7002);
    idle(); tick(6);
    chk(lg - base == 6, "R4", lg - base, 6);
    chk(l_ovc[base+4] == 1'b1 && l_ovc[base+5] == 1'b0, "R4",
        int'({l_ovc[base+4], l_ovc[base+5]}), 2);

    // R7: blocked output holds the packet in switch allocation
    out_block = 5'b00010;
    base = lg;
    send(0, K_HEAD, 16'h500B);
    send(0, K_TAIL, 16'hC0DE);
    idle(); tick(8);
    chk(lg == base, "R7", lg - base, 0);
    chk(stage_trace[1:0] == 2'd3, "R7", int'(stage_trace[1:0]), 3);
    out_block = 5'b00000;
    tick(1);
    chk(out_valid == 1'b1 && out_kind == K_HEAD, "R7", int'({out_valid, out_kind}), 5);
    tick(1);
    chk(out_valid == 1'b1 && out_data == 16'hC0DE, "R7", int'(out_data), 16'hC0DE);
    tick(4);

    // R8: three channels contend after a release of all outputs
    out_block = 5'b11111;
    base = lg;
    send(0, K_HEAD, 16'h600B);
    send(1, K_HEAD, 16'h6108);
    send(2, K_HEAD, 16'h620D);
    send(0, K_BODY, 16'h6300);
    send(1, K_BODY, 16'h6301);
    send(2, K_BODY, 16'h6302);
    send(0, K_TAIL, 16'h6400);
    send(1, K_TAIL, 16'h6401);
    send(2, K_TAIL, 16'h6402);
    idle(); tick(8);
    out_block = 5'b00000;
    tick(14);
    chk(lg - base == 9, "R8", lg - base, 9);
    chk(l_port[base] != l_port[base+1] && l_port[base+1] != l_port[base+2]
        && l_port[base] != l_port[base+2], "R8", int'(l_port[base+1]), -1);
    for (int i = 0; i < 6; i++)
      chk(l_port[base+i+3] == l_port[base+i], "R8", int'(l_port[base+i+3]), int'(l_port[base+i]));
    for (int i = 0; i < 9; i++) begin
      logic [1:0] ek;
      ek = (i < 3) ? K_HEAD : (i < 6) ? K_BODY : K_TAIL;
      chk(l_kind[base+i] == ek, "R8", int'(l_kind[base+i]), int'(ek));
    end

    // R9: full channel refuses and drops
    out_block = 5'b00010;
    base = lg;
    send(0, K_HEAD, 16'h900B);
    send(0, K_BODY, 16'h9001);
    send(0, K_BODY, 16'h9002);
    send(0, K_BODY, 16'h9003);
    send(0, K_BODY, 16'hDEAD);
    #1ns chk(in_ready == 1'b0, "R9", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0; in_vc = 2'd1;
    #1ns chk(in_ready == 1'b1, "R9", int'(in_ready), 1);
    in_vc = 2'd3;
    #1ns chk(in_ready == 1'b0, "R9", int'(in_ready), 0);
    in_vc = 2'd0;
    @(negedge clk);
    out_block = 5'b00000;
    tick(8);
    send(0, K_TAIL, 16'h9004);
    idle(); tick(6);
    chk(lg - base == 5, "R9", lg - base, 5);
    for (int i = 0; i < 5; i++) begin
      logic [DW-1:0] ed;
      ed = (i == 0) ? 16'h900B : 16'(16'h9000 + i);
      chk(l_data[base+i] == ed, "R9", int'(l_data[base+i]), int'(ed));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule